// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block models what a parallel NOR flash returns while it carries out an embedded program or erase. A synchronous host bus carries single-cycle read and write strobes, an address and write data. A command decoder recognises the unlock-and-command write sequences for word program, single-sector erase and whole-chip erase. A cycle-count timer then runs for each operation. While the operation runs, reads return a status byte in place of array data.

The status byte has four meaningful bits. A busy toggle on bit 6 flips on every read. A fault flag on bit 5 sets when a program tries to raise a 0 bit to 1 and the limit count elapses. A sector-erase marker sits on bit 3. An erase-sector toggle on bit 2 flips only on reads that fall inside a sector chosen for erasure. Each sector has a lock input. The block also supports erase suspend and resume, and a reset command that clears a fault.

The array is a small register file that resets to all ones. All durations are parameters counted in clock cycles. The sector number is taken from the top log2(NSECT) address bits.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, bus_rdata is 8'h00, the decoder is idle, and every array word reads 8'hFF with no status pattern.
- R2: The program sequence is AA at UNLOCK_A, 55 at UNLOCK_B, A0 at UNLOCK_A, then data at the target. Reads strobed up to T_PROG cycles after the fourth write return status. Reads after that return the new word.
- R3: A read in the busy states (program, erase, fault) returns the status byte and inverts bit 6 for the next read. Once the device is back in read mode, repeated reads return identical array data.
- R4: Reads made between the writes of an unfinished command sequence return array data. Status begins only with the fourth write (program) or the sixth write (erase).
- R5: A program aimed at a locked sector shows status for T_PROT_PROG cycles. It then returns to read mode with the word unchanged.
- R6: An erase in which every selected sector is locked shows status for T_PROT_ERASE cycles and leaves the array unchanged.
- R7: A program that would turn any 0 bit into 1 shows bit 5 = 0 for T_LIMIT cycles. After that the device enters a fault state where every read shows bit 5 = 1 and bit 6 keeps toggling.
- R8: In the fault state, only a write of F0 returns the device to read mode. An F0 write during an unfinished sequence abandons that sequence.
- R9: Status bit 3 reads 1 during a sector erase started with 30 at the sector address. It reads 0 during chip erase (10 at UNLOCK_A) and during program.
- R10: Status bit 2 inverts only on reads whose address is in a sector selected for erase. Reads of other sectors leave it as it was.
- R11: Writing B0 during an erase suspends it. The timer pauses. Reads of selected sectors keep bit 6 steady while bit 2 still toggles. Reads of other sectors return array data. Writing 30 resumes the erase.
- R12: When an erase finishes, every word of each selected, unlocked sector becomes 8'hFF. All other words keep their values.
- R13: Status bits 7, 4, 1 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Single-cycle write strobe; one strobe is one command cycle |
| bus_addr | input | AW | Word address; top bits select the sector |
| bus_wdata | input | 8 | Write data or command code |
| sect_lock | input | NSECT | Per-sector lock (1 = protected) |
| bus_rdata | output | 8 | Read result, registered one cycle after bus_rd |

## Verification
The assertions assume that bus_rd and bus_wr are never high in the same cycle. They also assume sect_lock only changes while the device is in read mode, so the lock sampled at a command's start is the same lock applied at its end. The bench drives every strobe from tasks at the falling edge, one strobe per cycle. It alters sect_lock only between operations, after waiting out the operation's full duration. Random program data is masked with the current word, so random traffic never raises the fault. The fault path is entered only in one directed case.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

    typedef enum logic [2:0] {
        ST_READ,
        ST_PROG,
        ST_ERASE,
        ST_SUSP,
        ST_FAULT
    } fsg_state_e;

    typedef enum logic [1:0] {
        OP_GOOD,
        OP_LOCKED,
        OP_BAD
    } op_kind_e;

    typedef enum logic [2:0] {
        DS_IDLE,
        DS_U1,
        DS_U2,
        DS_PGDATA,
        DS_E3,
        DS_E4,
        DS_E5
    } dec_step_e;

    localparam logic [7:0] CMD_KEY1    = 8'hAA;
    localparam logic [7:0] CMD_KEY2    = 8'h55;
    localparam logic [7:0] CMD_PROG    = 8'hA0;
    localparam logic [7:0] CMD_ESETUP  = 8'h80;
    localparam logic [7:0] CMD_SECT    = 8'h30;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;

    typedef struct packed {
        logic busy_tgl;
        logic fault;
        logic sect_mode;
        logic sel_tgl;
    } status_t;

    function automatic logic [7:0] pack_status(status_t s);
        return {1'b0, s.busy_tgl, s.fault, 1'b0, s.sect_mode, s.sel_tgl, 2'b00};
    endfunction

endpackage

// File: rtl/fsg_cmd_decoder.sv
module fsg_cmd_decoder
    import flash_status_pkg::*;
#(
    parameter int              AW       = 6,
    parameter logic [AW-1:0]   UNLOCK_A = '0,
    parameter logic [AW-1:0]   UNLOCK_B = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic          start_prog,
    output logic          start_serase,
    output logic          start_cerase
);

    dec_step_e step, step_nx;

    always_comb begin
        start_prog   = en && wr && (step == DS_PGDATA);
        start_serase = en && wr && (step == DS_E5) && (wdata == CMD_SECT);
        start_cerase = en && wr && (step == DS_E5) && (wdata == CMD_CHIP) && (addr == UNLOCK_A);
    end

    always_comb begin
        step_nx = step;
        if (!en) begin
            step_nx = DS_IDLE;
        end else if (wr) begin
            step_nx = DS_IDLE;
            unique case (step)
                DS_IDLE: if (wdata == CMD_KEY1 && addr == UNLOCK_A) step_nx = DS_U1;
                DS_U1:   if (wdata == CMD_KEY2 && addr == UNLOCK_B) step_nx = DS_U2;
                DS_U2: begin
                    if (wdata == CMD_PROG && addr == UNLOCK_A)        step_nx = DS_PGDATA;
                    else if (wdata == CMD_ESETUP && addr == UNLOCK_A) step_nx = DS_E3;
                end
                DS_PGDATA: step_nx = DS_IDLE;
                DS_E3:   if (wdata == CMD_KEY1 && addr == UNLOCK_A) step_nx = DS_E4;
                DS_E4:   if (wdata == CMD_KEY2 && addr == UNLOCK_B) step_nx = DS_E5;
                DS_E5:   step_nx = DS_IDLE;
                default: step_nx = DS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) step <= DS_IDLE;
        else     step <= step_nx;
    end

endmodule

// File: rtl/fsg_op_timer.sv
module fsg_op_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          done
);

    logic [CW-1:0] cnt;
    logic          active;

    assign done = active && run && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (load) begin
            cnt    <= load_val;
            active <= 1'b1;
        end else if (done) begin
            active <= 1'b0;
        end else if (active && run) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import flash_status_pkg::*;
#(
    parameter int            AW           = 6,
    parameter int            NSECT        = 4,
    parameter logic [AW-1:0] UNLOCK_A     = 6'h15,
    parameter logic [AW-1:0] UNLOCK_B     = 6'h2A,
    parameter int            T_PROG       = 40,
    parameter int            T_PROT_PROG  = 400,
    parameter int            T_ERASE      = 3000,
    parameter int            T_PROT_ERASE = 20000,
    parameter int            T_LIMIT      = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic [NSECT-1:0] sect_lock,
    output logic [7:0]       bus_rdata
);

    localparam int SW    = $clog2(NSECT);
    localparam int DEPTH = 1 << AW;
    localparam int WPS   = DEPTH / NSECT;
    localparam int TM1   = (T_PROG > T_PROT_PROG) ? T_PROG : T_PROT_PROG;
    localparam int TM2   = (T_ERASE > T_PROT_ERASE) ? T_ERASE : T_PROT_ERASE;
    localparam int TM3   = (TM1 > TM2) ? TM1 : TM2;
    localparam int TMAX  = (TM3 > T_LIMIT) ? TM3 : T_LIMIT;
    localparam int CW    = $clog2(TMAX + 1);

    fsg_state_e       st;
    op_kind_e         kind, new_kind;
    logic [AW-1:0]    tgt_addr;
    logic [7:0]       tgt_data;
    logic [NSECT-1:0] sel;
    logic             sect_mode;
    logic             t6, t2;
    logic [7:0]       mem [DEPTH];

    logic [SW-1:0]    addr_sect;
    logic             in_sel, show_status, busy_rd;
    logic             start_prog, start_serase, start_cerase;
    logic             tmr_load, tmr_done;
    logic [CW-1:0]    tmr_val;
    status_t          stat;

    assign addr_sect = bus_addr[AW-1 -: SW];
    assign in_sel    = sel[addr_sect];

    fsg_cmd_decoder #(.AW(AW), .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)) u_dec (
        .clk          (clk),
        .rst          (rst),
        .en           (st == ST_READ),
        .wr           (bus_wr),
        .addr         (bus_addr),
        .wdata        (bus_wdata),
        .start_prog   (start_prog),
        .start_serase (start_serase),
        .start_cerase (start_cerase)
    );

    fsg_op_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (st != ST_SUSP),
        .done     (tmr_done)
    );

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        new_kind = OP_GOOD;
        if (start_prog) begin
            tmr_load = 1'b1;
            if (sect_lock[addr_sect]) begin
                new_kind = OP_LOCKED;
                tmr_val  = CW'(T_PROT_PROG - 1);
            end else if ((bus_wdata & ~mem[bus_addr]) != 8'h00) begin
                new_kind = OP_BAD;
                tmr_val  = CW'(T_LIMIT - 1);
            end else begin
                tmr_val  = CW'(T_PROG - 1);
            end
        end else if (start_serase) begin
            tmr_load = 1'b1;
            tmr_val  = sect_lock[addr_sect] ? CW'(T_PROT_ERASE - 1) : CW'(T_ERASE - 1);
        end else if (start_cerase) begin
            tmr_load = 1'b1;
            tmr_val  = (&sect_lock) ? CW'(T_PROT_ERASE - 1) : CW'(T_ERASE - 1);
        end
    end

    always_comb begin
        busy_rd     = (st == ST_PROG) || (st == ST_ERASE) || (st == ST_FAULT);
        show_status = busy_rd || ((st == ST_SUSP) && in_sel);
        stat        = '{busy_tgl: t6, fault: (st == ST_FAULT), sect_mode: sect_mode, sel_tgl: t2};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_READ;
            kind      <= OP_GOOD;
            tgt_addr  <= '0;
            tgt_data  <= '0;
            sel       <= '0;
            sect_mode <= 1'b0;
            t6        <= 1'b0;
            t2        <= 1'b0;
            bus_rdata <= '0;
        end else begin
            if (bus_rd) begin
                bus_rdata <= show_status ? pack_status(stat) : mem[bus_addr];
                if (busy_rd) t6 <= ~t6;
                if (((st == ST_ERASE) || (st == ST_SUSP)) && in_sel) t2 <= ~t2;
            end
            unique case (st)
                ST_READ: begin
                    if (start_prog) begin
                        st       <= ST_PROG;
                        kind     <= new_kind;
                        tgt_addr <= bus_addr;
                        tgt_data <= bus_wdata;
                    end else if (start_serase) begin
                        st        <= ST_ERASE;
                        sel       <= NSECT'(1) << addr_sect;
                        sect_mode <= 1'b1;
                    end else if (start_cerase) begin
                        st        <= ST_ERASE;
                        sel       <= '1;
                        sect_mode <= 1'b0;
                    end
                end
                ST_PROG: begin
                    if (tmr_done) st <= (kind == OP_BAD) ? ST_FAULT : ST_READ;
                end
                ST_ERASE: begin
                    if (tmr_done) begin
                        st        <= ST_READ;
                        sel       <= '0;
                        sect_mode <= 1'b0;
                    end else if (bus_wr && bus_wdata == CMD_SUSPEND) begin
                        st <= ST_SUSP;
                    end
                end
                ST_SUSP: begin
                    if (bus_wr && bus_wdata == CMD_SECT) st <= ST_ERASE;
                end
                ST_FAULT: begin
                    if (bus_wr && bus_wdata == CMD_RESET) st <= ST_READ;
                end
                default: st <= ST_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (st == ST_PROG && tmr_done && kind == OP_GOOD) begin
            mem[tgt_addr] <= tgt_data;
        end else if (st == ST_ERASE && tmr_done) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (sel[SW'(i / WPS)] && !sect_lock[SW'(i / WPS)]) mem[i] <= 8'hFF;
            end
        end
    end

endmodule

// File: rtl/fsg_checker.sv
module fsg_checker
    import flash_status_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input fsg_state_e st,
    input logic       t6
);

    // R3
    busy_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (st == ST_PROG || st == ST_ERASE || st == ST_FAULT)) |=> (t6 != $past(t6)));

    // R11
    idle_toggle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (st == ST_READ || st == ST_SUSP)) |=> (t6 == $past(t6)));

    // R7
    fault_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && st == ST_FAULT) |=> bus_rdata[5]);

    // R8
    fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FAULT && !(bus_wr && bus_wdata == CMD_RESET)) |=> (st == ST_FAULT));

    // R9
    prog_no_sect_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && st == ST_PROG) |=> !bus_rdata[3]);

    // R11
    suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SUSP && !(bus_wr && bus_wdata == CMD_SECT)) |=> (st == ST_SUSP));

    // R13
    zero_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (st == ST_PROG || st == ST_ERASE || st == ST_FAULT))
        |=> (bus_rdata[7] == 1'b0 && bus_rdata[4] == 1'b0 && bus_rdata[1:0] == 2'b00));

endmodule

bind flash_status_gen fsg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .st        (st),
    .t6        (t6)
);

// File: tb/tb_flash_status_gen.sv
`timescale 1ns/1ps
module tb_flash_status_gen;

    localparam int            AW  = 6;
    localparam int            NS  = 4;
    localparam logic [AW-1:0] U1  = 6'h15;
    localparam logic [AW-1:0] U2  = 6'h2A;
    localparam int            TP  = 20;
    localparam int            TPP = 15;
    localparam int            TE  = 50;
    localparam int            TPE = 35;
    localparam int            TL  = 25;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_rd, bus_wr;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata;
    logic [NS-1:0] sect_lock;
    logic [7:0]    bus_rdata;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic [7:0] model [64];
    logic [7:0] s1, s2, s3, s4, q;

    always #2.5 clk = ~clk;

    flash_status_gen #(
        .AW(AW), .NSECT(NS), .UNLOCK_A(U1), .UNLOCK_B(U2),
        .T_PROG(TP), .T_PROT_PROG(TPP), .T_ERASE(TE), .T_PROT_ERASE(TPE), .T_LIMIT(TL)
    ) dut (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .sect_lock(sect_lock), .bus_rdata(bus_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] r);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        r = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic prog_seq(input logic [AW-1:0] a, input logic [7:0] d);
        wr(U1, 8'hAA); wr(U2, 8'h55); wr(U1, 8'hA0); wr(a, d);
    endtask

    task automatic erase_pre();
        wr(U1, 8'hAA); wr(U2, 8'h55); wr(U1, 8'h80); wr(U1, 8'hAA); wr(U2, 8'h55);
    endtask

    function automatic logic [7:0] exp_stat(input logic b6, input logic b5, input logic b3, input logic b2);
        return {1'b0, b6, b5, 1'b0, b3, b2, 2'b00};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all) actual=%h expected=%h", 8'h00, 8'h01);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) model[i] = 8'hFF;
        rst = 1'b1; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; sect_lock = '0;
        idle(4);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(bus_rdata == 8'h00, "R1 rdata after reset", bus_rdata, 8'h00);
        rd(6'h05, q);
        chk(q == 8'hFF, "R1 erased word", q, 8'hFF);
        rd(6'h3E, q);
        chk(q == 8'hFF, "R1 erased word high", q, 8'hFF);

        // R4 partial sequence returns array data
        wr(U1, 8'hAA);
        rd(6'h03, q);
        chk(q == 8'hFF, "R4 read after 1st write", q, 8'hFF);
        wr(U2, 8'h55); wr(U1, 8'hA0);
        rd(6'h03, q);
        chk(q == 8'hFF, "R4 read after 3rd write", q, 8'hFF);
        wr(6'h03, 8'hA5);
        model[3] = 8'hA5;
        rd(6'h03, s1); rd(6'h20, s2);
        chk(s1[6] != s2[6], "R3 bit6 toggles during program", s2, {s1[7], ~s1[6], s1[5:0]});
        chk(s1 == exp_stat(s1[6], 1'b0, 1'b0, s1[2]), "R9 R13 program status bits", s1, exp_stat(s1[6], 1'b0, 1'b0, s1[2]));
        chk(s1[2] == s2[2], "R10 bit2 steady in program", s2[2], s1[2]);
        idle(TP - 4);
        rd(6'h03, s3);
        rd(6'h03, s4);
        chk(s4[7] == 1'b0, "R2 still busy at last timed cycle", s4, exp_stat(s4[6], 1'b0, 1'b0, s4[2]));
        rd(6'h03, q);
        chk(q == 8'hA5, "R2 program result", q, 8'hA5);
        rd(6'h03, q);
        chk(q == 8'hA5, "R3 no toggle after completion", q, 8'hA5);

        // R2 random programs in sectors 1 and 2
        for (int k = 0; k < 16; k++) begin
            logic [AW-1:0] a;
            logic [7:0]    d;
            a = AW'(6'h10 + ($urandom % 32));
            d = model[a] & 8'($urandom);
            prog_seq(a, d);
            model[a] = d;
            idle(TP);
            rd(a, q);
            chk(q == d, "R2 random program", q, d);
        end
        for (int k = 0; k < 8; k++) begin
            logic [AW-1:0] a;
            a = AW'($urandom % 64);
            rd(a, q);
            chk(q == model[a], "R2 random read", q, model[a]);
        end

        // setup word in sector 3 then lock it
        prog_seq(6'h31, 8'h96);
        model[6'h31] = 8'h96;
        idle(TP + 2);
        sect_lock = 4'b1000;

        // R5 locked program
        prog_seq(6'h31, 8'h00);
        rd(6'h31, s1); rd(6'h31, s2);
        chk(s1[6] != s2[6] && s1[7] == 1'b0, "R5 locked program shows status", s2, {1'b0, ~s1[6], s1[5:0]});
        idle(TPP - 4);
        rd(6'h31, s3); rd(6'h31, s4);
        chk(s4[7] == 1'b0, "R5 busy through locked window", s4, exp_stat(s4[6], 1'b0, 1'b0, s4[2]));
        rd(6'h31, q);
        chk(q == 8'h96, "R5 locked word unchanged", q, 8'h96);

        // R7 fault on 0->1 program
        prog_seq(6'h03, 8'hFF);
        rd(6'h03, s1);
        chk(s1[5] == 1'b0 && s1[7] == 1'b0, "R7 no fault early", s1, exp_stat(s1[6], 1'b0, 1'b0, s1[2]));
        idle(TL - 3);
        rd(6'h03, s2); rd(6'h03, s3);
        chk(s3[5] == 1'b0, "R7 no fault at limit", s3, exp_stat(s3[6], 1'b0, 1'b0, s3[2]));
        rd(6'h03, s3); rd(6'h11, s4);
        chk(s3[5] == 1'b1, "R7 fault flag set", s3, exp_stat(s3[6], 1'b1, 1'b0, s3[2]));
        chk(s4[5] == 1'b1 && s4[6] != s3[6], "R7 fault toggling", s4, exp_stat(~s3[6], 1'b1, 1'b0, s3[2]));
        prog_seq(6'h12, 8'h00);
        idle(TP + 4);
        rd(6'h12, q);
        chk(q[5] == 1'b1 && q[7] == 1'b0, "R8 fault ignores other writes", q, exp_stat(q[6], 1'b1, 1'b0, q[2]));
        wr(6'h00, 8'hF0);
        rd(6'h03, q);
        chk(q == 8'hA5, "R8 reset command restores read", q, 8'hA5);
        rd(6'h12, q);
        chk(q == model[6'h12], "R8 no program during fault", q, model[6'h12]);

        // R9 R10 R11 sector erase of sector 0 with suspend
        erase_pre();
        rd(6'h03, q);
        chk(q == 8'hA5, "R4 read after 5th write", q, 8'hA5);
        wr(6'h00, 8'h30);
        rd(6'h02, s1); rd(6'h03, s2);
        chk(s1[3] == 1'b1 && s2[3] == 1'b1, "R9 sector mode flag", s1, exp_stat(s1[6], 1'b0, 1'b1, s1[2]));
        chk(s1[2] != s2[2], "R10 bit2 toggles in selected sector", s2[2], ~s1[2]);
        rd(6'h22, s3); rd(6'h23, s4);
        chk(s3[2] == s4[2], "R10 bit2 held outside selection", s4[2], s3[2]);
        chk(s3[6] != s4[6], "R3 bit6 toggles at any address", s4[6], ~s3[6]);
        wr(6'h00, 8'hB0);
        rd(6'h02, s1); rd(6'h02, s2);
        chk(s1[6] == s2[6], "R11 bit6 steady in suspend", s2[6], s1[6]);
        chk(s1[2] != s2[2], "R11 bit2 toggles in suspend", s2[2], ~s1[2]);
        rd(6'h22, q);
        chk(q == model[6'h22], "R11 unselected reads array", q, model[6'h22]);
        idle(TE + 10);
        rd(6'h02, q);
        chk(q == exp_stat(s2[6], 1'b0, 1'b1, ~s2[2]), "R11 timer paused", q, exp_stat(s2[6], 1'b0, 1'b1, ~s2[2]));
        wr(6'h00, 8'h30);
        rd(6'h02, s1); rd(6'h02, s2);
        chk(s1[6] != s2[6], "R11 resume toggles again", s2[6], ~s1[6]);
        idle(TE + 2);
        for (int i = 0; i < 16; i++) model[i] = 8'hFF;
        rd(6'h03, q);
        chk(q == 8'hFF, "R12 sector erased", q, 8'hFF);
        rd(6'h22, q);
        chk(q == model[6'h22], "R12 other sector kept", q, model[6'h22]);

        // R9 R10 R12 chip erase with sector 3 locked
        erase_pre();
        wr(U1, 8'h10);
        rd(6'h12, s1); rd(6'h25, s2);
        chk(s1[3] == 1'b0, "R9 chip erase flag clear", s1, exp_stat(s1[6], 1'b0, 1'b0, s1[2]));
        chk(s1[2] != s2[2], "R10 all sectors selected", s2[2], ~s1[2]);
        idle(TE + 2);
        for (int i = 0; i < 48; i++) model[i] = 8'hFF;
        rd(6'h12, q);
        chk(q == 8'hFF, "R12 chip erase clears unlocked", q, 8'hFF);
        rd(6'h31, q);
        chk(q == 8'h96, "R12 chip erase keeps locked", q, 8'h96);

        // R6 erase with every selected sector locked
        erase_pre();
        wr(6'h30, 8'h30);
        rd(6'h31, s1);
        chk(s1 == exp_stat(s1[6], 1'b0, 1'b1, s1[2]), "R6 locked erase status", s1, exp_stat(s1[6], 1'b0, 1'b1, s1[2]));
        idle(TPE - 3);
        rd(6'h31, s2); rd(6'h31, s3);
        chk(s3[7] == 1'b0, "R6 busy through locked window", s3, exp_stat(s3[6], 1'b0, 1'b1, s3[2]));
        rd(6'h31, q);
        chk(q == 8'h96, "R6 array unchanged", q, 8'h96);

        // R8 F0 abandons a partial sequence
        wr(U1, 8'hAA); wr(U2, 8'h55); wr(6'h00, 8'hF0); wr(U1, 8'hA0); wr(6'h12, 8'h00);
        idle(TP + 2);
        rd(6'h12, q);
        chk(q == 8'hFF, "R8 aborted sequence no program", q, 8'hFF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule